// File: doc/BRIEF.md
# SDRAM Read Path with Synchronous Termination

This block sits between a 32-bit CPU bus and an SDRAM device. It handles reads that fall inside a configurable SDRAM address window. For each such read it issues a read command and keeps that command and its column address on the pins for two consecutive clocks. It then counts a fixed CAS latency and samples the data bus on the one cycle the device drives it. In the cycle the data register loads, it pulses a one-clock synchronous termination strobe, so the CPU latches the word in that same cycle and no wait state is ever inserted.

A read is always a full 32-bit word. The CPU picks the byte lanes it needs. Row activation, refresh and device setup belong to another controller, which this block sees only as a ready input. Ready is consulted only before a command is issued.

Addresses outside the window are routed to a slow path. That path forwards the slow device's acknowledge to the CPU after a parameterised number of clocks. This delay applies only to the slow path and never touches SDRAM timing.

Top module: `syncterm_rd_path`

## Requirements
- R1: A read command to SDRAM (`sd_rd_cmd` high) lasts exactly two consecutive clocks. `sd_col` equals `cpu_addr[COL_W+1:2]` and stays unchanged through both clocks.
- R2: The word on `sd_dq` is sampled in the cycle that lies `CAS_LAT` clocks after the first command clock. `cpu_sterm` is high in the next cycle, `CAS_LAT+1` clocks after the first command clock.
- R3: `cpu_sterm` is high for exactly one clock per SDRAM read. In that clock `cpu_data` holds the sampled word. At all other times `cpu_sterm` is low.
- R4: `CAS_LAT` is a parameter that may be 2 (the default) or 3. The timing in R2 holds for both values.
- R5: There is no transfer-size input. All 32 bits of `cpu_data` equal the 32 bits driven on `sd_dq` in the sampled cycle.
- R6: Once a command is issued, nothing stretches the cycle. Dropping `mem_ready` after the command does not move the termination strobe.
- R7: SDRAM reads never raise `cpu_ack`. Slow-path cycles never raise `sd_rd_cmd` or `cpu_sterm`.
- R8: On the slow path, `cpu_ack` rises `ACK_DLY` clocks (default 3) after `slow_ack_in` rises. `cpu_ack` falls one clock after `cpu_strobe` is negated. `slow_sel` is high while a slow cycle is in progress.
- R9: A read command starts only when `cpu_strobe` and `mem_ready` were both high in the preceding clock. While `mem_ready` is low, no command is issued.
- R10: After termination, no further command is issued until `cpu_strobe` has been negated.
- R11: While `rst` is high, `sd_rd_cmd`, `cpu_sterm`, `cpu_ack` and `slow_sel` are low.
- R12: An address selects SDRAM exactly when `(cpu_addr & WIN_MASK) == WIN_BASE`. With the defaults 0xF8000000 and 0x08000000, 0x08000000 through 0x0FFFFFFC select SDRAM and neighbouring addresses do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_strobe | input | 1 | CPU address strobe, active high |
| cpu_addr | input | ADDR_W | CPU byte address |
| mem_ready | input | 1 | SDRAM row/refresh controller ready |
| sd_dq | input | DATA_W | SDRAM read data bus |
| slow_ack_in | input | 1 | Acknowledge from slow memory |
| sd_rd_cmd | output | 1 | SDRAM read command / CAS, active high |
| sd_col | output | COL_W | SDRAM column address |
| cpu_data | output | DATA_W | Captured read word to CPU |
| cpu_sterm | output | 1 | Synchronous termination strobe |
| slow_sel | output | 1 | Slow region selected |
| cpu_ack | output | 1 | Delayed asynchronous acknowledge to CPU |

## Verification
Two instances are run side by side, one with CAS latency 2 and one with CAS latency 3. Each is connected to a bus model that drives valid data for one cycle only and garbage at all other times, so a capture that is one cycle early or late produces a wrong word. The read addresses are chosen to tell a wrong column slice or window decode apart from a correct one: the window edges on both sides, the top and bottom column values, and an address with low bits set. Directed runs cover three more cases: ready held low before a command, ready dropped during a command, and the strobe held after termination. A slow-path cycle is timed to the exact acknowledge clock, which separates a delay that is too short from one that is too long.

// File: rtl/syncterm_pkg.sv
package syncterm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD1,
    ST_CMD2,
    ST_WAIT,
    ST_HOLD
  } issue_state_t;
endpackage

// File: rtl/syncterm_addr_decode.sv
module syncterm_addr_decode #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h0800_0000,
  parameter logic [31:0] WIN_MASK = 32'hF800_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output logic              sel_sdram,
  output logic              sel_slow
);
  localparam logic [ADDR_W-1:0] BASE_L = WIN_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] MASK_L = WIN_MASK[ADDR_W-1:0];

  logic in_win;
  always_comb begin
    in_win    = ((addr & MASK_L) == BASE_L);
    sel_sdram = strobe && in_win;
    sel_slow  = strobe && !in_win;
  end
endmodule

// File: rtl/syncterm_issue_fsm.sv
module syncterm_issue_fsm
  import syncterm_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             sel_sdram,
  input  logic             mem_ready,
  input  logic             cap_now,
  input  logic [COL_W-1:0] col_in,
  output logic             launch,
  output logic             sd_rd_cmd,
  output logic [COL_W-1:0] sd_col
);
  issue_state_t state;

  always_comb begin
    launch = (state == ST_IDLE) && sel_sdram && mem_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sd_rd_cmd <= 1'b0;
      sd_col    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state     <= ST_CMD1;
            sd_rd_cmd <= 1'b1;
            sd_col    <= col_in;
          end
        end
        ST_CMD1: begin
          state <= ST_CMD2;
        end
        ST_CMD2: begin
          state     <= ST_WAIT;
          sd_rd_cmd <= 1'b0;
        end
        ST_WAIT: begin
          if (cap_now) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!strobe) state <= ST_IDLE;
        end
        default: begin
          state     <= ST_IDLE;
          sd_rd_cmd <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/syncterm_cap_pipe.sv
module syncterm_cap_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] sd_dq,
  output logic              cap_now,
  output logic [DATA_W-1:0] cpu_data,
  output logic              cpu_sterm
);
  localparam int PIPE_LEN = CAS_LAT + 1;

  logic [PIPE_LEN-1:0] lat_pipe;

  always_comb begin
    cap_now = lat_pipe[PIPE_LEN-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_pipe  <= '0;
      cpu_sterm <= 1'b0;
      cpu_data  <= '0;
    end else begin
      lat_pipe  <= {lat_pipe[PIPE_LEN-2:0], launch};
      cpu_sterm <= cap_now;
      if (cap_now) cpu_data <= sd_dq;
    end
  end
endmodule

// File: rtl/syncterm_slow_ack.sv
module syncterm_slow_ack #(
  parameter int ACK_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_slow,
  input  logic slow_ack_in,
  output logic slow_sel,
  output logic cpu_ack
);
  logic [ACK_DLY-1:0] ack_sr;

  generate
    if (ACK_DLY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || !sel_slow) ack_sr <= '0;
        else                  ack_sr <= slow_ack_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst || !sel_slow) ack_sr <= '0;
        else                  ack_sr <= {ack_sr[ACK_DLY-2:0], slow_ack_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) slow_sel <= 1'b0;
    else     slow_sel <= sel_slow;
  end

  always_comb begin
    cpu_ack = ack_sr[ACK_DLY-1];
  end
endmodule

// File: rtl/syncterm_rd_path.sv
module syncterm_rd_path #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          COL_W    = 10,
  parameter int          CAS_LAT  = 2,
  parameter int          ACK_DLY  = 3,
  parameter logic [31:0] WIN_BASE = 32'h0800_0000,
  parameter logic [31:0] WIN_MASK = 32'hF800_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_strobe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] sd_dq,
  input  logic              slow_ack_in,
  output logic              sd_rd_cmd,
  output logic [COL_W-1:0]  sd_col,
  output logic [DATA_W-1:0] cpu_data,
  output logic              cpu_sterm,
  output logic              slow_sel,
  output logic              cpu_ack
);
  localparam int COL_LO = 2;
  localparam int COL_HI = COL_W + COL_LO - 1;

  logic sel_sdram;
  logic sel_slow;
  logic launch;
  logic cap_now;

  syncterm_addr_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_MASK(WIN_MASK)
  ) u_dec (
    .addr     (cpu_addr),
    .strobe   (cpu_strobe),
    .sel_sdram(sel_sdram),
    .sel_slow (sel_slow)
  );

  syncterm_issue_fsm #(
    .COL_W(COL_W)
  ) u_issue (
    .clk      (clk),
    .rst      (rst),
    .strobe   (cpu_strobe),
    .sel_sdram(sel_sdram),
    .mem_ready(mem_ready),
    .cap_now  (cap_now),
    .col_in   (cpu_addr[COL_HI:COL_LO]),
    .launch   (launch),
    .sd_rd_cmd(sd_rd_cmd),
    .sd_col   (sd_col)
  );

  syncterm_cap_pipe #(
    .CAS_LAT(CAS_LAT),
    .DATA_W (DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .sd_dq    (sd_dq),
    .cap_now  (cap_now),
    .cpu_data (cpu_data),
    .cpu_sterm(cpu_sterm)
  );

  syncterm_slow_ack #(
    .ACK_DLY(ACK_DLY)
  ) u_slow (
    .clk        (clk),
    .rst        (rst),
    .sel_slow   (sel_slow),
    .slow_ack_in(slow_ack_in),
    .slow_sel   (slow_sel),
    .cpu_ack    (cpu_ack)
  );
endmodule

// File: rtl/syncterm_rd_checker.sv
module syncterm_rd_checker #(
  parameter int COL_W   = 10,
  parameter int CAS_LAT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_strobe,
  input logic             mem_ready,
  input logic             sd_rd_cmd,
  input logic [COL_W-1:0] sd_col,
  input logic             cpu_sterm,
  input logic             cpu_ack
);
  logic       cmd_prev;
  logic [3:0] since_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_prev  <= 1'b0;
      since_cmd <= '0;
    end else begin
      cmd_prev <= sd_rd_cmd;
      if (sd_rd_cmd && !cmd_prev)  since_cmd <= 4'd1;
      else if (since_cmd != 4'd0 && since_cmd != 4'hF) since_cmd <= since_cmd + 4'd1;
    end
  end

  // R1: command and column held for the second clock
  a_r1_col_held: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_rd_cmd) |=> (sd_rd_cmd && $stable(sd_col)));

  // R1: no third command clock
  a_r1_two_only: assert property (@(posedge clk) disable iff (rst)
    (sd_rd_cmd && cmd_prev) |=> !sd_rd_cmd);

  // R2: termination lands CAS_LAT+1 clocks after the first command clock
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    cpu_sterm |-> (since_cmd == 4'(CAS_LAT + 1)));

  // R3: strobe lasts a single clock
  a_r3_one_clock: assert property (@(posedge clk) disable iff (rst)
    cpu_sterm |=> !cpu_sterm);

  // R7: the two termination paths never overlap
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cpu_sterm && cpu_ack));

  // R9: command starts only after strobe and ready
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_rd_cmd) |-> ($past(cpu_strobe) && $past(mem_ready)));

  // R10: no command right after termination
  a_r10_no_reissue: assert property (@(posedge clk) disable iff (rst)
    cpu_sterm |-> !sd_rd_cmd);
endmodule

bind syncterm_rd_path syncterm_rd_checker #(
  .COL_W  (COL_W),
  .CAS_LAT(CAS_LAT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_strobe(cpu_strobe),
  .mem_ready (mem_ready),
  .sd_rd_cmd (sd_rd_cmd),
  .sd_col    (sd_col),
  .cpu_sterm (cpu_sterm),
  .cpu_ack   (cpu_ack)
);

// File: tb/syncterm_rd_path_bench.sv
`timescale 1ns/1ps
module syncterm_sd_model #(
  parameter int CL = 2
) (
  input  logic        clk,
  input  logic        cmd,
  input  logic [9:0]  col,
  output logic [31:0] dq
);
  logic       prev;
  int         cnt;
  logic [9:0] lc;

  function automatic logic [31:0] pat(input logic [9:0] c);
    return ({22'd0, c} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  initial begin
    dq   = 32'hDEAD_BEEF;
    prev = 1'b0;
    cnt  = -1;
    lc   = '0;
  end

  always @(posedge clk) begin
    #1;
    if (cnt > 0) cnt = cnt - 1;
    if (cmd && !prev) begin
      cnt = CL;
      lc  = col;
    end
    prev = cmd;
    if (cnt == 0) begin
      dq  = pat(lc);
      cnt = -1;
    end else begin
      dq = 32'hDEAD_BEEF;
    end
  end
endmodule

module syncterm_rd_path_bench;
  localparam int CL_A    = 2;
  localparam int CL_B    = 3;
  localparam int ACK_DLY = 3;
  localparam int NVEC    = 8;

  // [33:2] address, [1] SDRAM expected, [0] drop ready during command
  localparam logic [33:0] VEC [NVEC] = '{
    {32'h0800_0000, 1'b1, 1'b0},
    {32'h0800_0FFC, 1'b1, 1'b0},
    {32'h0ABC_D554, 1'b1, 1'b0},
    {32'h0FFF_FFFC, 1'b1, 1'b1},
    {32'h07FF_FFFC, 1'b0, 1'b0},
    {32'h1000_0000, 1'b0, 1'b0},
    {32'h0812_3457, 1'b1, 1'b0},
    {32'h8000_0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [31:0] addr = '0;
  logic        ready = 1'b1;
  logic        slow_ack = 1'b0;

  logic        cmd_a, cmd_b, st_a, st_b, ss_a, ss_b, ack_a, ack_b;
  logic [9:0]  col_a, col_b;
  logic [31:0] dq_a, dq_b, dat_a, dat_b;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  syncterm_rd_path u_syncterm_rd_path (
    .clk(clk), .rst(rst), .cpu_strobe(strobe), .cpu_addr(addr), .mem_ready(ready),
    .sd_dq(dq_a), .slow_ack_in(slow_ack), .sd_rd_cmd(cmd_a), .sd_col(col_a),
    .cpu_data(dat_a), .cpu_sterm(st_a), .slow_sel(ss_a), .cpu_ack(ack_a)
  );

  syncterm_rd_path #(.CAS_LAT(CL_B)) u_syncterm_rd_path_cl3 (
    .clk(clk), .rst(rst), .cpu_strobe(strobe), .cpu_addr(addr), .mem_ready(ready),
    .sd_dq(dq_b), .slow_ack_in(slow_ack), .sd_rd_cmd(cmd_b), .sd_col(col_b),
    .cpu_data(dat_b), .cpu_sterm(st_b), .slow_sel(ss_b), .cpu_ack(ack_b)
  );

  syncterm_sd_model #(.CL(CL_A)) u_mdl_a (.clk(clk), .cmd(cmd_a), .col(col_a), .dq(dq_a));
  syncterm_sd_model #(.CL(CL_B)) u_mdl_b (.clk(clk), .cmd(cmd_b), .col(col_b), .dq(dq_b));

  function automatic logic [31:0] exp_word(input logic [9:0] c);
    return ({22'd0, c} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic sdram_read(input logic [31:0] a, input bit drop);
    int fa = -1, fb = -1, ta = -1, tb = -1;
    int na = 0, nb = 0, sa = 0, sb = 0;
    bit colbad = 0, ackseen = 0;
    logic [31:0] ca = '0, cb = '0;
    logic [9:0] ec = a[11:2];
    @(negedge clk);
    strobe = 1'b1;
    addr   = a;
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      if (cmd_a) begin if (fa < 0) fa = n; na++; if (col_a != ec) colbad = 1; end
      if (cmd_b) begin if (fb < 0) fb = n; nb++; if (col_b != ec) colbad = 1; end
      if (drop && cmd_a) ready = 1'b0;
      if (st_a) begin ta = n; sa++; ca = dat_a; end
      if (st_b) begin tb = n; sb++; cb = dat_b; end
      if (ack_a || ack_b) ackseen = 1;
    end
    chk(na == 2 && nb == 2, "R1 command clocks", na, 2);
    chk(!colbad, "R1 column held", {22'd0, col_a}, {22'd0, ec});
    chk(ta - fa == CL_A + 1, "R2 latency CL2", ta - fa, CL_A + 1);
    chk(tb - fb == CL_B + 1, "R4 latency CL3", tb - fb, CL_B + 1);
    chk(sa == 1 && sb == 1, "R3 single strobe", sa, 1);
    chk(ca == exp_word(ec), "R5 word CL2", ca, exp_word(ec));
    chk(cb == exp_word(ec), "R5 word CL3", cb, exp_word(ec));
    chk(!ackseen, "R7 no ack on SDRAM", ackseen, 0);
    if (drop) chk(ta - fa == CL_A + 1, "R6 ready drop no stretch", ta - fa, CL_A + 1);
    strobe = 1'b0;
    ready  = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic slow_cycle(input logic [31:0] a, input string tag);
    int first = -1;
    bit bad = 0;
    @(negedge clk);
    strobe = 1'b1;
    addr   = a;
    repeat (2) begin
      @(negedge clk);
      if (ack_a || cmd_a || st_a || cmd_b || st_b) bad = 1;
    end
    chk(ss_a && ss_b, "R8 slow_sel", ss_a, 1);
    slow_ack = 1'b1;
    for (int k = 1; k <= ACK_DLY + 2; k++) begin
      @(negedge clk);
      if (ack_a && first < 0) first = k;
      if (cmd_a || st_a || cmd_b || st_b) bad = 1;
    end
    chk(first == ACK_DLY, {"R8 ack delay ", tag}, first, ACK_DLY);
    chk(!bad, {"R7 slow path quiet ", tag}, bad, 0);
    strobe   = 1'b0;
    slow_ack = 1'b0;
    @(negedge clk);
    chk(!ack_a && !ack_b, "R8 ack clears", ack_a, 0);
    @(negedge clk);
  endtask

  initial begin
    strobe = 1'b1;
    addr   = 32'h0800_0100;
    repeat (3) @(negedge clk);
    chk(!cmd_a && !st_a && !ack_a && !ss_a && !cmd_b, "R11 reset outputs", {cmd_a, st_a, ack_a, ss_a}, 0);
    strobe = 1'b0;
    rst    = 1'b0;
    repeat (2) @(negedge clk);

    // R12 window decode and main read path walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][1]) sdram_read(VEC[i][33:2], VEC[i][0]);
      else           slow_cycle(VEC[i][33:2], "R12 outside window");
    end

    // R9: ready low holds off the command
    begin
      bit early = 0;
      int seen = 0;
      ready  = 1'b0;
      @(negedge clk);
      strobe = 1'b1;
      addr   = 32'h0800_0040;
      repeat (5) begin
        @(negedge clk);
        if (cmd_a || cmd_b) early = 1;
      end
      chk(!early, "R9 no command while not ready", early, 0);
      ready = 1'b1;
      @(negedge clk);
      seen = cmd_a && cmd_b;
      chk(seen == 1, "R9 command after ready", seen, 1);
      repeat (8) @(negedge clk);
      strobe = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R10: strobe held after termination, no reissue; then a fresh read works
    begin
      int cnt = 0;
      @(negedge clk);
      strobe = 1'b1;
      addr   = 32'h0800_0200;
      repeat (20) begin
        @(negedge clk);
        if (cmd_a) cnt++;
      end
      chk(cnt == 2, "R10 no reissue while strobe held", cnt, 2);
      strobe = 1'b0;
      repeat (2) @(negedge clk);
    end
    sdram_read(32'h0800_0204, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule